// File: doc/BRIEF.md
# Fine Frequency Trim Unit

This block nudges the rate of a time-of-day counter by asking it to add or drop one nanosecond at a steady, programmable spacing. Software loads a 30-bit spacing value, together with a bit that says whether the spacing is counted in picoseconds or in nanoseconds. It also loads a control word with an enable bit and a sign bit. Each clock, the block adds the nominal clock period, expressed in the selected unit, to an internal accumulator. When the accumulator reaches the spacing value, it emits a one-cycle correction pulse and keeps the surplus for the next round.

The time counter consumes the pulse. It applies one extra nanosecond when the sign output is low, which makes time run faster. It skips one nanosecond when the sign output is high, which makes time run slower. Converting a parts-per-million offset into a spacing value is left to software. When the result does not fit in 30 bits, software disables the unit instead.

Top module: `fine_trim_unit`

## Requirements
- R1: After synchronous reset, both outputs are low, both registers are zero, and no pulse appears until the unit is enabled with a nonzero spacing.
- R2: While the enable bit is low, no pulse is produced and the accumulator is held at zero. Writing an all-zero control word therefore stops all correction, and a later enable starts counting from zero.
- R3: With unit bit 0 (picoseconds), the accumulator grows by PERIOD_PS per clock. After a spacing write, the first pulse appears on the edge where the running sum first reaches the spacing value, that is, ceil(spacing/PERIOD_PS) edges after the write edge.
- R4: With unit bit 1 (nanoseconds), the accumulator grows by PERIOD_PS/1000 per clock, with the same pulse rule as R3.
- R5: When a pulse is produced, the accumulator keeps the sum minus the spacing. The spacing between pulses therefore averages spacing/step clocks.
- R6: corr_slow equals the enable-time sign bit (1 = slow down, drop 1 ns; 0 = speed up, add 1 ns) on a pulse cycle, and is low whenever corr_pulse is low.
- R7: A spacing write restarts the accumulator from zero. If the same edge would have produced a pulse, that pulse is suppressed.
- R8: A spacing value of zero produces no pulses.
- R9: If the surplus left after a pulse is still at least the spacing (spacing below the step), the accumulator is cleared instead. The unit then pulses on every clock while enabled.
- R10: Register writes take effect from the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_wr | input | 1 | Write strobe for the spacing register |
| freq_unit_ns | input | 1 | Unit select: 1 = nanoseconds, 0 = picoseconds |
| freq_interval | input | 30 | Spacing value |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_enable | input | 1 | Enable bit |
| cfg_slow | input | 1 | Sign bit: 1 = negative correction |
| corr_pulse | output | 1 | One-cycle correction request |
| corr_slow | output | 1 | Sign of the current correction |

## Verification
A spacing write and a pulse can fall on the same clock edge. The restart must win, so no pulse is emitted on that edge and the count begins again from zero. The bench provokes this by tracking its own accumulator model and issuing the rewrite on exactly the cycle in which the running sum would reach the spacing. It then judges that corr_pulse stays low after that edge and that the next pulse arrives a full ceil(spacing/step) edges later. A control write that disables the unit on a would-be pulse edge is also covered: per R10, the pulse still emits and silence follows.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int IW = 30;
    localparam int AW = IW + 1;

    typedef logic [IW-1:0] interval_t;
    typedef logic [AW-1:0] acc_t;

    typedef struct packed {
        logic      unit_ns;
        interval_t interval;
    } freq_reg_t;

    typedef struct packed {
        logic enable;
        logic slow;
    } cfg_reg_t;

    typedef struct packed {
        logic pulse;
        logic slow;
    } corr_t;

    // per-clock increment in the selected unit
    function automatic acc_t step_for(input logic unit_ns, input int period_ps);
        return unit_ns ? acc_t'(period_ps / 1000) : acc_t'(period_ps);
    endfunction

    // surplus after a pulse; cleared when it would still reach the spacing
    function automatic acc_t carry_after(input acc_t sum, input interval_t iv);
        acc_t rem;
        rem = sum - {1'b0, iv};
        return (rem >= {1'b0, iv}) ? '0 : rem;
    endfunction

endpackage

// File: rtl/trim_regs.sv
module trim_regs
    import trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      freq_wr,
    input  freq_reg_t freq_wdata,
    input  logic      cfg_wr,
    input  cfg_reg_t  cfg_wdata,
    output freq_reg_t freq_q,
    output cfg_reg_t  cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (freq_wr) freq_q <= freq_wdata;
            if (cfg_wr)  cfg_q  <= cfg_wdata;
        end
    end

endmodule

// File: rtl/trim_accum.sv
module trim_accum
    import trim_pkg::*;
#(
    parameter int PERIOD_PS = 5000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  freq_reg_t freq_q,
    input  cfg_reg_t  cfg_q,
    output acc_t      acc_q,
    output logic      hit
);

    localparam acc_t STEP_PS = step_for(1'b0, PERIOD_PS);
    localparam acc_t STEP_NS = step_for(1'b1, PERIOD_PS);

    acc_t step;
    acc_t sum;
    acc_t acc_d;
    logic active;

    always_comb begin
        step   = freq_q.unit_ns ? STEP_NS : STEP_PS;
        sum    = acc_q + step;
        active = cfg_q.enable && (freq_q.interval != '0) && !restart;
        hit    = active && (sum >= {1'b0, freq_q.interval});
        if (!active)
            acc_d = '0;
        else if (hit)
            acc_d = carry_after(sum, freq_q.interval);
        else
            acc_d = sum;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

endmodule

// File: rtl/trim_pulse_out.sv
module trim_pulse_out
    import trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  logic  slow,
    output corr_t corr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_q <= '0;
        end else begin
            corr_q.pulse <= hit;
            corr_q.slow  <= hit & slow;
        end
    end

endmodule

// File: rtl/fine_trim_unit.sv
module fine_trim_unit
    import trim_pkg::*;
#(
    parameter int PERIOD_PS = 5000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          freq_wr,
    input  logic          freq_unit_ns,
    input  logic [IW-1:0] freq_interval,
    input  logic          cfg_wr,
    input  logic          cfg_enable,
    input  logic          cfg_slow,
    output logic          corr_pulse,
    output logic          corr_slow
);

    freq_reg_t freq_q;
    cfg_reg_t  cfg_q;
    acc_t      acc_q;
    logic      hit;
    corr_t     corr_q;

    logic      en_q;
    interval_t interval_q;

    trim_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .freq_wr    (freq_wr),
        .freq_wdata ('{unit_ns: freq_unit_ns, interval: freq_interval}),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  ('{enable: cfg_enable, slow: cfg_slow}),
        .freq_q     (freq_q),
        .cfg_q      (cfg_q)
    );

    trim_accum #(.PERIOD_PS(PERIOD_PS)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .restart (freq_wr),
        .freq_q  (freq_q),
        .cfg_q   (cfg_q),
        .acc_q   (acc_q),
        .hit     (hit)
    );

    trim_pulse_out u_out (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .slow   (cfg_q.slow),
        .corr_q (corr_q)
    );

    assign corr_pulse = corr_q.pulse;
    assign corr_slow  = corr_q.slow;
    assign en_q       = cfg_q.enable;
    assign interval_q = freq_q.interval;

endmodule

// File: rtl/trim_checker.sv
module trim_checker
    import trim_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      freq_wr,
    input logic      corr_pulse,
    input logic      corr_slow,
    input logic      en_q,
    input interval_t interval_q,
    input acc_t      acc_q
);

    a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !corr_pulse);

    a_r7_restart_suppresses: assert property (@(posedge clk) disable iff (rst)
        freq_wr |=> !corr_pulse);

    a_r8_zero_interval_silent: assert property (@(posedge clk) disable iff (rst)
        (interval_q == '0) |=> !corr_pulse);

    a_r6_sign_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        !corr_pulse |-> !corr_slow);

    a_r5_acc_bounded: assert property (@(posedge clk) disable iff (rst)
        (acc_q == '0) || (acc_q < {1'b0, interval_q}));

endmodule

bind fine_trim_unit trim_checker u_trim_checker (
    .clk        (clk),
    .rst        (rst),
    .freq_wr    (freq_wr),
    .corr_pulse (corr_pulse),
    .corr_slow  (corr_slow),
    .en_q       (en_q),
    .interval_q (interval_q),
    .acc_q      (acc_q)
);

// File: tb/test_fine_trim_unit.sv
module test_fine_trim_unit;

    localparam int PS = 5000;
    localparam int NS_STEP = PS / 1000;

    typedef struct packed {
        logic        unit_ns;
        logic [29:0] interval;
        logic        enable;
        logic        slow;
        logic [7:0]  cycles;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 30'd20000, 1'b1, 1'b0, 8'd30, 4'd3},
        '{1'b0, 30'd12000, 1'b1, 1'b1, 8'd30, 4'd5},
        '{1'b1, 30'd23,    1'b1, 1'b0, 8'd30, 4'd4},
        '{1'b0, 30'd0,     1'b1, 1'b0, 8'd12, 4'd8},
        '{1'b0, 30'd20000, 1'b0, 1'b1, 8'd20, 4'd2},
        '{1'b0, 30'd3000,  1'b1, 1'b1, 8'd12, 4'd9},
        '{1'b1, 30'd20,    1'b1, 1'b1, 8'd24, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freq_wr = 1'b0;
    logic        freq_unit_ns = 1'b0;
    logic [29:0] freq_interval = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_slow = 1'b0;
    logic        corr_pulse;
    logic        corr_slow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // independent model of the requirements
    logic        m_unit = 1'b0;
    logic [29:0] m_iv = '0;
    logic        m_en = 1'b0;
    logic        m_slow = 1'b0;
    longint      m_acc = 0;
    logic        m_pulse = 1'b0;
    logic        m_sign = 1'b0;

    always #2.5 clk = ~clk;

    fine_trim_unit #(.PERIOD_PS(PS)) i_fine_trim_unit (
        .clk(clk), .rst(rst), .freq_wr(freq_wr), .freq_unit_ns(freq_unit_ns),
        .freq_interval(freq_interval), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_slow(cfg_slow), .corr_pulse(corr_pulse), .corr_slow(corr_slow)
    );

    always @(posedge clk) begin
        longint step, sum, rem;
        if (rst) begin
            m_unit = 0; m_iv = 0; m_en = 0; m_slow = 0;
            m_acc = 0; m_pulse = 0; m_sign = 0;
        end else begin
            step = m_unit ? NS_STEP : PS;
            sum  = m_acc + step;
            if (freq_wr || !m_en || m_iv == 0) begin
                m_acc = 0; m_pulse = 0; m_sign = 0;
            end else if (sum >= m_iv) begin
                rem = sum - m_iv;
                m_acc = (rem >= m_iv) ? 0 : rem;
                m_pulse = 1; m_sign = m_slow;
            end else begin
                m_acc = sum; m_pulse = 0; m_sign = 0;
            end
            if (freq_wr) begin m_unit = freq_unit_ns; m_iv = freq_interval; end
            if (cfg_wr)  begin m_en = cfg_enable; m_slow = cfg_slow; end
        end
    end

    function automatic string req_name(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            8: return "R8";
            9: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag);
        @(negedge clk);
        check(tag, corr_pulse, m_pulse, "corr_pulse");
        check(tag, corr_slow, m_sign, "corr_slow");
        freq_wr = 1'b0;
        cfg_wr  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", corr_pulse, 1'b0, "reset pulse");
        check("R1", corr_slow, 1'b0, "reset sign");
        rst = 1'b0;
        cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_slow = 1'b0;
        cyc("R1");
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            cyc("R1");
            pulses += corr_pulse;
        end
        check("R1", pulses != 0, 1'b0, "pulse with zero spacing after reset");

        // table-driven patterns
        for (int v = 0; v < 7; v++) begin
            freq_wr = 1'b1; freq_unit_ns = VECS[v].unit_ns; freq_interval = VECS[v].interval;
            cfg_wr = 1'b1; cfg_enable = VECS[v].enable; cfg_slow = VECS[v].slow;
            for (int c = 0; c < int'(VECS[v].cycles); c++) cyc(req_name(int'(VECS[v].req)));
        end

        // R3: first pulse exactly 4 edges after a 20000 ps write (R10 timing)
        freq_wr = 1'b1; freq_unit_ns = 1'b0; freq_interval = 30'd20000;
        cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_slow = 1'b0;
        cyc("R3");
        for (int i = 1; i < 4; i++) begin
            cyc("R3");
            check("R3", corr_pulse, 1'b0, "early pulse");
        end
        cyc("R3");
        check("R3", corr_pulse, 1'b1, "pulse at fourth edge");

        // R7: spacing write on the would-be pulse edge
        while (m_acc != 15000) cyc("R7");
        freq_wr = 1'b1; freq_unit_ns = 1'b0; freq_interval = 30'd20000;
        cyc("R7");
        check("R7", corr_pulse, 1'b0, "pulse despite restart");
        for (int i = 1; i < 4; i++) begin
            cyc("R7");
            check("R7", corr_pulse, 1'b0, "pulse before full spacing after restart");
        end
        cyc("R7");
        check("R7", corr_pulse, 1'b1, "pulse after restart");

        // R10/R2: disable on a would-be pulse edge; pulse still emitted, then silence
        while (m_acc != 15000) cyc("R10");
        cfg_wr = 1'b1; cfg_enable = 1'b0; cfg_slow = 1'b0;
        cyc("R10");
        check("R10", corr_pulse, 1'b1, "pulse on disable edge");
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            cyc("R2");
            pulses += corr_pulse;
        end
        check("R2", pulses != 0, 1'b0, "pulse while disabled");

        // R2: re-enable starts counting from zero
        cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_slow = 1'b1;
        cyc("R2");
        for (int i = 1; i < 4; i++) begin
            cyc("R2");
            check("R2", corr_pulse, 1'b0, "stale accumulator after enable");
        end
        cyc("R6");
        check("R6", corr_slow, 1'b1, "slow sign on pulse");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule